// File: doc/BRIEF.md
# Burst Address Sequencer for a Synchronous SRAM

This block is the address front end of a synchronous SRAM that accepts a new access on every clock. At each rising edge, one shared control input decides between two things. It either captures an external start address for a new burst, or it steps an internal two-bit counter to produce the next address of the current burst. Only the two lowest address bits follow the burst sequence. The upper bits keep the value captured at the start.

A strap-style order input picks the sequence. In linear order the low bits count up modulo four. In interleaved order they are the start bits XOR the step number. Every access that is issued leaves the block as an effective address with a valid strobe, after one of two timings:

- **Flow-through:** the effective address and valid strobe come straight from the first address register.
- **Pipelined:** one more register stage is added.

A sleep input puts the block into standby. In standby no access is issued and advance requests are ignored.

Top module: `burst_seq_top`

## Requirements
- R1: With `adv` = 0 and `sleep` = 0 at a rising edge, `addr_in` is captured as the burst start, the burst step resets to 0, and the issued address equals `addr_in`.
- R2: With `adv` = 1 and `sleep` = 0, the step count increments by one. The issued address keeps bits [ADDR_W-1:2] of the last captured start unchanged.
- R3: With `order` = 0 (linear), the low two bits of the issued address are (start low bits + step) modulo 4.
- R4: With `order` = 1 (interleaved), the low two bits of the issued address are start low bits XOR step.
- R5: The step counter is two bits wide. The fourth advance after a load issues the start address again.
- R6: With the block in flow-through mode (`pipe_mode` = 0), the result of an access issued at a rising edge appears on `eff_addr`/`eff_valid` right after that same edge.
- R7: With the block in pipelined mode (`pipe_mode` = 1), that result appears one clock later, after the following rising edge.
- R8: With `sleep` = 1 at an edge, no access is issued (`eff_valid` = 0 for that slot). The step counter does not move, even if `adv` = 1.
- R9: A new access can be issued at every edge without idle cycles, including back-to-back loads.
- R10: Reset is synchronous and active high. It clears the start address and step to 0, drives `eff_valid` to 0, and sets `pipe_mode` to 1 (the default timing). An advance issued first after reset therefore produces address 1.
- R11: `pipe_mode` equals the value `pipe_sel` had at the previous rising edge. 1 means pipelined and 0 means flow-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | External start address, captured on load |
| adv | input | 1 | 1 = advance the burst, 0 = load a new start |
| order | input | 1 | 0 = linear burst order, 1 = interleaved |
| pipe_sel | input | 1 | 1 = pipelined output timing, 0 = flow-through |
| sleep | input | 1 | 1 = standby, no accesses issued |
| eff_addr | output | ADDR_W | Effective access address for the array |
| eff_valid | output | 1 | An access is presented on eff_addr |
| pipe_mode | output | 1 | Output timing currently in force |

## Verification
The bench builds the block with ADDR_W = 12, so addresses are short enough to read at a glance. With that width it still chooses start addresses whose upper field is all ones. Those addresses expose any carry leaking from the low-bit sequence into the held upper bits across a wrap. It runs the same sequences once in flow-through mode and once in pipelined mode after a reset, so the scoreboard latency differs by exactly one slot between the two runs.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Number of address bits that take part in a burst (four-beat bursts).
  localparam int BURST_BITS = 2;

  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } burst_order_e;

  // Low address bits for a given start value and step number.
  function automatic logic [BURST_BITS-1:0] burst_low(
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] step,
    input burst_order_e          ord
  );
    if (ord == ORD_INTERLEAVED) return start ^ step;
    else                        return start + step;
  endfunction
endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              adv,
  input  burst_order_e      ord,
  input  logic              sleep,
  output logic [ADDR_W-1:0] iss_addr,
  output logic              iss_vld
);
  localparam int BB = BURST_BITS;

  logic [ADDR_W-1:0] base_q;
  logic [BB-1:0]     step_q;
  logic [BB-1:0]     step_nx;
  logic [BB-1:0]     low_nx;

  always_comb begin
    step_nx = step_q + BB'(1);
    low_nx  = burst_low(base_q[BB-1:0], step_nx, ord);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      step_q   <= '0;
      iss_addr <= '0;
      iss_vld  <= 1'b0;
    end else begin
      iss_vld <= !sleep;
      if (!sleep) begin
        if (!adv) begin
          base_q   <= ld_addr;
          step_q   <= '0;
          iss_addr <= ld_addr;
        end else begin
          step_q   <= step_nx;
          iss_addr <= {base_q[ADDR_W-1:BB], low_nx};
        end
      end
    end
  end
endmodule

// File: rtl/burst_out_stage.sv
module burst_out_stage #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_sel,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_vld,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_vld,
  output logic              pipe_mode
);
  logic              pipe_q;
  logic [ADDR_W-1:0] reg_addr;
  logic              reg_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q   <= 1'b1;
      reg_addr <= '0;
      reg_vld  <= 1'b0;
    end else begin
      pipe_q   <= pipe_sel;
      reg_addr <= in_addr;
      reg_vld  <= in_vld;
    end
  end

  always_comb begin
    out_addr  = pipe_q ? reg_addr : in_addr;
    out_vld   = pipe_q ? reg_vld  : in_vld;
    pipe_mode = pipe_q;
  end
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              adv,
  input  logic              order,
  input  logic              pipe_sel,
  input  logic              sleep,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              eff_valid,
  output logic              pipe_mode
);
  logic [ADDR_W-1:0] iss_addr;
  logic              iss_vld;
  burst_order_e      ord;

  assign ord = burst_order_e'(order);

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .ld_addr  (addr_in),
    .adv      (adv),
    .ord      (ord),
    .sleep    (sleep),
    .iss_addr (iss_addr),
    .iss_vld  (iss_vld)
  );

  burst_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .pipe_sel  (pipe_sel),
    .in_addr   (iss_addr),
    .in_vld    (iss_vld),
    .out_addr  (eff_addr),
    .out_vld   (eff_valid),
    .pipe_mode (pipe_mode)
  );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_in,
  input logic              adv,
  input logic              order,
  input logic              pipe_sel,
  input logic              sleep,
  input logic [ADDR_W-1:0] eff_addr,
  input logic              eff_valid,
  input logic              pipe_mode
);
  localparam int BB = BURST_BITS;

  AST_FLOW_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!sleep && !adv) && !pipe_mode)
      |-> (eff_valid && eff_addr == $past(addr_in))); // R1

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(adv && !sleep) && !pipe_mode && !$past(pipe_mode))
      |-> (eff_addr[ADDR_W-1:BB] == $past(eff_addr[ADDR_W-1:BB]))); // R2

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(adv && !sleep && !order)
      && $past(!sleep && !order, 2) && !pipe_mode && !$past(pipe_mode))
      |-> ((eff_addr[BB-1:0] - $past(eff_addr[BB-1:0])) == BB'(1))); // R3

  AST_FLOW_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sleep) && !pipe_mode) |-> !eff_valid); // R8

  AST_PIPE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(!sleep && !adv, 2) && pipe_mode)
      |-> (eff_valid && eff_addr == $past(addr_in, 2))); // R7

  AST_MODE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pipe_mode == $past(pipe_sel))); // R11
endmodule

bind burst_seq_top burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .addr_in   (addr_in),
  .adv       (adv),
  .order     (order),
  .pipe_sel  (pipe_sel),
  .sleep     (sleep),
  .eff_addr  (eff_addr),
  .eff_valid (eff_valid),
  .pipe_mode (pipe_mode)
);

// File: tb/tb_burst_seq_top.sv
module tb_burst_seq_top;
  localparam int AW         = 12;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic          vld;
    logic [AW-1:0] addr;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          adv = 1'b1;
  logic          order = 1'b0;
  logic          pipe_sel = 1'b1;
  logic          sleep = 1'b1;
  logic [AW-1:0] eff_addr;
  logic          eff_valid;
  logic          pipe_mode;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  bit done = 1'b0;
  item_t q[$];

  logic [AW-1:0] m_base;
  logic [1:0]    m_step;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_seq_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .adv(adv), .order(order),
    .pipe_sel(pipe_sel), .sleep(sleep), .eff_addr(eff_addr),
    .eff_valid(eff_valid), .pipe_mode(pipe_mode)
  );

  function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] n, logic o);
    return o ? (s ^ n) : (s + n);
  endfunction

  task automatic check_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  // Monitor: pops expected items once the output latency has elapsed.
  always @(negedge clk) begin
    if (!rst) begin
      while (q.size() > lat) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (eff_valid !== it.vld || (it.vld && eff_addr !== it.addr)) begin
          errors++;
          $display("FAIL %s %s: got vld=%0b addr=%h expected vld=%0b addr=%h",
                   it.tag, (lat != 0) ? "R7" : "R6",
                   eff_valid, eff_addr, it.vld, it.addr);
        end
      end
    end
  end

  task automatic step(input logic a, input logic [AW-1:0] ad, input logic slp,
                      input string tag);
    item_t it;
    @(negedge clk);
    adv = a; addr_in = ad; sleep = slp;
    @(posedge clk);
    it.tag = tag;
    it.vld = !slp;
    it.addr = '0;
    if (!slp) begin
      if (!a) begin
        m_base = ad;
        m_step = 2'd0;
        it.addr = ad;
      end else begin
        m_step = m_step + 2'd1;
        it.addr = {m_base[AW-1:2], exp_low(m_base[1:0], m_step, order)};
      end
    end
    q.push_back(it);
  endtask

  task automatic do_reset(input logic pmode);
    @(negedge clk);
    rst = 1'b1; sleep = 1'b1; adv = 1'b1; pipe_sel = pmode;
    q.delete();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_bit("R10 valid in reset", eff_valid, 1'b0);
    check_bit("R10 mode in reset", pipe_mode, 1'b1);
    rst = 1'b0;
    m_base = '0;
    m_step = 2'd0;
    lat = pmode ? 1 : 0;
  endtask

  task automatic run_sequences();
    step(1'b1, '0, 1'b0, "R10 first advance");
    order = 1'b0;
    step(1'b0, 12'hFFD, 1'b0, "R1 load");
    step(1'b1, '0, 1'b0, "R2 R3 step1");
    step(1'b1, '0, 1'b0, "R2 R3 step2");
    step(1'b1, '0, 1'b0, "R2 R3 step3");
    step(1'b1, '0, 1'b0, "R5 linear wrap");
    order = 1'b1;
    step(1'b0, 12'hA85, 1'b0, "R1 load");
    step(1'b1, '0, 1'b0, "R4 step1");
    step(1'b1, '0, 1'b0, "R4 step2");
    step(1'b1, '0, 1'b0, "R4 step3");
    step(1'b1, '0, 1'b0, "R5 interleaved wrap");
    step(1'b0, 12'h3C2, 1'b0, "R1 load");
    step(1'b1, '0, 1'b0, "R4 step1");
    step(1'b1, '0, 1'b1, "R8 sleep adv");
    step(1'b1, '0, 1'b1, "R8 sleep adv");
    step(1'b1, '0, 1'b0, "R8 step held");
    order = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step(1'b0, AW'(12'h100 + i * 37), 1'b0, "R9 back-to-back load");
      step(1'b1, '0, 1'b0, "R9 back-to-back advance");
    end
    step(1'b1, '0, 1'b1, "R8 drain");
    step(1'b1, '0, 1'b1, "R8 drain");
  endtask

  initial begin
    do_reset(1'b0);
    run_sequences();
    @(negedge clk);
    check_bit("R11 flow mode", pipe_mode, 1'b0);
    do_reset(1'b1);
    run_sequences();
    @(negedge clk);
    check_bit("R11 pipelined mode", pipe_mode, 1'b1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule